// File: doc/BRIEF.md
# Receive Aggregation Window Controller

This block decides when an open receive aggregation buffer has to be closed. Packets are presented one at a time with a byte length and an end-of-frame marker. Accepted packets are packed back to back into one receive buffer. The controller keeps a running byte total, a packet count, and a timer that starts with the first write into an empty buffer. From these it decides, in the same cycle that a packet is presented, whether the packet is written into the current buffer (accept) or must wait for the next buffer (defer). It also signals the close of the buffer with a one-cycle pulse that carries a reason code.

Closing can be caused by a byte boundary, by a timer, by an end-of-frame marker, or by a packet count. The byte boundary works in one of two modes. In the soft mode the packet that reaches the boundary is still written, and the buffer closes after it. In the hard mode a packet that would cross the boundary is held back, so it becomes the first packet of the next buffer. The timer counts pulses from one of two external tick sources. All settings are static inputs. When aggregation is switched off, every packet gets a buffer of its own.

Top module: `rxagg_window`

## Requirements
- R1: After reset no close is signalled, `close_reason` is 0 and the buffer is empty, so the first packet is accepted. `close_pulse` is a registered one-cycle pulse. It is high in the cycle after the clock edge that samples the deciding packet or tick. `close_reason` encodes 0 = byte boundary, 1 = timer, 2 = end-of-frame, 3 = packet count.
- R2: The byte boundary is `cfg_limit_kb` × 1024. In soft mode (`cfg_hard_mode`=0) a packet that brings the byte total to the boundary or beyond is accepted, and the buffer closes with reason 0.
- R3: In hard mode, a packet that would take the total of a non-empty buffer above the boundary gets `pkt_defer`=1 and `pkt_accept`=0. The buffer closes with reason 0, and the same packet presented again is accepted into the new buffer. A packet that brings the total exactly to the boundary is accepted and closes with reason 0.
- R4: In hard mode, a packet larger than the whole boundary that arrives at an empty buffer is accepted, and it closes the buffer with reason 0.
- R5: The timer counts selected ticks that are sampled after the edge of the first write. The tick that completes `cfg_time_limit` ticks closes the buffer with reason 1. Ticks that arrive while the buffer is empty are not counted.
- R6: A `cfg_time_limit` of 0 disables the timer, and no tick closes the buffer.
- R7: `cfg_tick_sel`=0 counts `tick_100us`, and `cfg_tick_sel`=1 counts `tick_1ms`. The tick that is not selected has no effect.
- R8: With `cfg_eof_close`=1, an accepted packet with `pkt_eof`=1 closes the buffer with reason 2. With `cfg_eof_close`=0 the marker is ignored and the packet's bytes remain in the open buffer.
- R9: A nonzero `cfg_pkt_limit` closes the buffer with reason 3 on the accepted packet that brings the count to the limit. A value of 0 sets no packet limit.
- R10: With `cfg_aggr_en`=0, every presented packet is accepted and closes with reason 3, whatever its length. Hard mode, end-of-frame and timer settings are then ignored.
- R11: When several causes meet in one cycle, the byte boundary is chosen first, then end-of-frame, then packet count, then the timer.
- R12: A close resets the byte total, the packet count and the timer. The timer stays idle until the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_aggr_en | input | 1 | Aggregation enable |
| cfg_hard_mode | input | 1 | 1 = hard byte boundary, 0 = soft |
| cfg_eof_close | input | 1 | Close on end-of-frame packet |
| cfg_limit_kb | input | KB_W | Byte boundary in units of 1024 bytes |
| cfg_time_limit | input | TIME_W | Timer length in ticks, 0 = off |
| cfg_tick_sel | input | 1 | 0 = 100 us tick, 1 = 1 ms tick |
| cfg_pkt_limit | input | PKT_W | Packets per buffer, 0 = unlimited |
| tick_100us | input | 1 | 100 us granularity pulse |
| tick_1ms | input | 1 | 1 ms granularity pulse |
| pkt_valid | input | 1 | Packet presented this cycle |
| pkt_len | input | LEN_W | Packet length in bytes |
| pkt_eof | input | 1 | Packet ends a frame |
| pkt_accept | output | 1 | Packet is written into the current buffer |
| pkt_defer | output | 1 | Packet must be presented again for the next buffer |
| close_pulse | output | 1 | Buffer closes (one cycle) |
| close_reason | output | 2 | Close cause code |

## Verification
The assertions check several properties on every cycle. Accept and defer never occur together. A defer happens only in hard mode with data already in the buffer, and it is always followed by a byte-boundary close. With aggregation off, every packet is followed by a count close. The timer stays at zero while the buffer is empty and never reaches its limit. Other behaviours can only be shown by the bench scenarios: the exact boundary arithmetic in both modes, the re-presentation of a deferred packet, which tick source is counted, the priority between reasons that meet in one cycle, and that an ignored end-of-frame leaves its bytes in the buffer.

// File: rtl/rxagg_pkg.sv
package rxagg_pkg;

    typedef enum logic [1:0] {
        RSN_BYTES = 2'd0,
        RSN_TIMER = 2'd1,
        RSN_EOF   = 2'd2,
        RSN_COUNT = 2'd3
    } close_rsn_e;

    typedef struct packed {
        logic       fire;
        close_rsn_e rsn;
    } close_req_t;

    localparam int KB_SHIFT = 10;

    function automatic int cnt_width(input int kb_w, input int len_w);
        return ((kb_w + KB_SHIFT > len_w) ? kb_w + KB_SHIFT : len_w) + 1;
    endfunction

endpackage

// File: rtl/rxagg_fill.sv
module rxagg_fill
    import rxagg_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int KB_W  = 6,
    parameter int PKT_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_aggr_en,
    input  logic              cfg_hard_mode,
    input  logic              cfg_eof_close,
    input  logic [KB_W-1:0]   cfg_limit_kb,
    input  logic [PKT_W-1:0]  cfg_pkt_limit,
    input  logic              pkt_valid,
    input  logic [LEN_W-1:0]  pkt_len,
    input  logic              pkt_eof,
    input  logic              close_any,
    output logic              pkt_accept,
    output logic              pkt_defer,
    output logic              has_data,
    output close_req_t        pkt_req
);
    localparam int CNT_W = cnt_width(KB_W, LEN_W);

    logic [CNT_W-1:0] byte_cnt;
    logic [PKT_W-1:0] pkt_cnt;
    logic [CNT_W-1:0] boundary;
    logic [CNT_W-1:0] sum;
    logic [PKT_W-1:0] pkt_nx;
    logic             hard_block;

    always_comb begin
        boundary   = CNT_W'(cfg_limit_kb) << KB_SHIFT;
        sum        = byte_cnt + CNT_W'(pkt_len);
        pkt_nx     = (&pkt_cnt) ? pkt_cnt : pkt_cnt + 1'b1;
        hard_block = pkt_valid && cfg_aggr_en && cfg_hard_mode && has_data && (sum > boundary);
        pkt_accept = pkt_valid && !hard_block;
        pkt_defer  = hard_block;
        pkt_req    = '{fire: 1'b0, rsn: RSN_BYTES};
        if (hard_block) begin
            pkt_req = '{fire: 1'b1, rsn: RSN_BYTES};
        end else if (pkt_accept) begin
            if (!cfg_aggr_en)
                pkt_req = '{fire: 1'b1, rsn: RSN_COUNT};
            else if (sum >= boundary)
                pkt_req = '{fire: 1'b1, rsn: RSN_BYTES};
            else if (cfg_eof_close && pkt_eof)
                pkt_req = '{fire: 1'b1, rsn: RSN_EOF};
            else if (cfg_pkt_limit != '0 && pkt_nx >= cfg_pkt_limit)
                pkt_req = '{fire: 1'b1, rsn: RSN_COUNT};
        end
    end

    assign has_data = (pkt_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst || close_any) begin
            byte_cnt <= '0;
            pkt_cnt  <= '0;
        end else if (pkt_accept) begin
            byte_cnt <= sum;
            pkt_cnt  <= pkt_nx;
        end
    end

    // R3: a packet is never both written and held back
    p_acc_def_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(pkt_accept && pkt_defer));

    // R3, R4: holding back needs hard mode and a non-empty buffer
    p_defer_hard_r3: assert property (@(posedge clk) disable iff (rst)
        pkt_defer |-> (cfg_hard_mode && cfg_aggr_en && $past(pkt_accept) || cfg_hard_mode && has_data));

    // R12: an open buffer stays below its boundary between packets
    p_open_below_r12: assert property (@(posedge clk) disable iff (rst)
        (has_data && cfg_aggr_en) |-> (byte_cnt < boundary));
endmodule

// File: rtl/rxagg_timer.sv
module rxagg_timer #(
    parameter int TIME_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_aggr_en,
    input  logic [TIME_W-1:0] cfg_time_limit,
    input  logic              cfg_tick_sel,
    input  logic              tick_100us,
    input  logic              tick_1ms,
    input  logic              has_data,
    input  logic              close_any,
    output logic              timeout
);
    logic [TIME_W-1:0] tmr;
    logic              tick;
    logic              run;

    always_comb begin
        tick    = cfg_tick_sel ? tick_1ms : tick_100us;
        run     = cfg_aggr_en && (cfg_time_limit != '0) && has_data;
        timeout = run && tick && (tmr == cfg_time_limit - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst || close_any)
            tmr <= '0;
        else if (run && tick)
            tmr <= tmr + 1'b1;
    end

    // R12: timer idle while the buffer is empty
    p_timer_idle_r12: assert property (@(posedge clk) disable iff (rst)
        !has_data |-> (tmr == '0));

    // R5: the count never reaches the limit without closing
    p_timer_bound_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg_time_limit != '0) |-> (tmr < cfg_time_limit));
endmodule

// File: rtl/rxagg_arb.sv
module rxagg_arb
    import rxagg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  close_req_t pkt_req,
    input  logic       timeout,
    output logic       close_any,
    output logic       close_pulse,
    output logic [1:0] close_reason
);
    close_rsn_e rsn_nx;

    always_comb begin
        close_any = pkt_req.fire || timeout;
        rsn_nx    = pkt_req.fire ? pkt_req.rsn : RSN_TIMER;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            close_pulse  <= 1'b0;
            close_reason <= 2'd0;
        end else begin
            close_pulse  <= close_any;
            close_reason <= close_any ? rsn_nx : 2'd0;
        end
    end

    // R11: a packet-driven cause always beats the timer
    p_pkt_wins_r11: assert property (@(posedge clk) disable iff (rst)
        (pkt_req.fire && timeout) |=> (close_pulse && close_reason != 2'd1));
endmodule

// File: rtl/rxagg_window.sv
module rxagg_window
    import rxagg_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int KB_W   = 6,
    parameter int TIME_W = 8,
    parameter int PKT_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_aggr_en,
    input  logic              cfg_hard_mode,
    input  logic              cfg_eof_close,
    input  logic [KB_W-1:0]   cfg_limit_kb,
    input  logic [TIME_W-1:0] cfg_time_limit,
    input  logic              cfg_tick_sel,
    input  logic [PKT_W-1:0]  cfg_pkt_limit,
    input  logic              tick_100us,
    input  logic              tick_1ms,
    input  logic              pkt_valid,
    input  logic [LEN_W-1:0]  pkt_len,
    input  logic              pkt_eof,
    output logic              pkt_accept,
    output logic              pkt_defer,
    output logic              close_pulse,
    output logic [1:0]        close_reason
);
    close_req_t pkt_req;
    logic       has_data;
    logic       timeout;
    logic       close_any;

    rxagg_fill #(.LEN_W(LEN_W), .KB_W(KB_W), .PKT_W(PKT_W)) u_fill (
        .clk(clk), .rst(rst),
        .cfg_aggr_en(cfg_aggr_en), .cfg_hard_mode(cfg_hard_mode),
        .cfg_eof_close(cfg_eof_close), .cfg_limit_kb(cfg_limit_kb),
        .cfg_pkt_limit(cfg_pkt_limit),
        .pkt_valid(pkt_valid), .pkt_len(pkt_len), .pkt_eof(pkt_eof),
        .close_any(close_any),
        .pkt_accept(pkt_accept), .pkt_defer(pkt_defer),
        .has_data(has_data), .pkt_req(pkt_req)
    );

    rxagg_timer #(.TIME_W(TIME_W)) u_timer (
        .clk(clk), .rst(rst),
        .cfg_aggr_en(cfg_aggr_en), .cfg_time_limit(cfg_time_limit),
        .cfg_tick_sel(cfg_tick_sel),
        .tick_100us(tick_100us), .tick_1ms(tick_1ms),
        .has_data(has_data), .close_any(close_any),
        .timeout(timeout)
    );

    rxagg_arb u_arb (
        .clk(clk), .rst(rst),
        .pkt_req(pkt_req), .timeout(timeout),
        .close_any(close_any),
        .close_pulse(close_pulse), .close_reason(close_reason)
    );

    // R3: a held-back packet is followed by a byte-boundary close
    p_defer_closes_r3: assert property (@(posedge clk) disable iff (rst)
        pkt_defer |=> (close_pulse && close_reason == 2'd0));

    // R10: without aggregation each packet closes its own buffer
    p_single_pkt_r10: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && !cfg_aggr_en) |=> (close_pulse && close_reason == 2'd3));

    // R1: a close always has a packet or a tick behind it
    p_close_cause_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(close_pulse) |-> $past(pkt_valid || tick_100us || tick_1ms));
endmodule

// File: tb/test_rxagg_window.sv
module test_rxagg_window;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_aggr_en = 1'b1;
    logic        cfg_hard_mode = 1'b0;
    logic        cfg_eof_close = 1'b0;
    logic [5:0]  cfg_limit_kb = 6'd1;
    logic [7:0]  cfg_time_limit = 8'd0;
    logic        cfg_tick_sel = 1'b0;
    logic [5:0]  cfg_pkt_limit = 6'd0;
    logic        tick_100us = 1'b0;
    logic        tick_1ms = 1'b0;
    logic        pkt_valid = 1'b0;
    logic [15:0] pkt_len = '0;
    logic        pkt_eof = 1'b0;
    logic        pkt_accept, pkt_defer, close_pulse;
    logic [1:0]  close_reason;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    int    exp_rsn_q[$];
    string exp_req_q[$];

    always #2 clk = ~clk;

    rxagg_window i_rxagg_window (
        .clk(clk), .rst(rst),
        .cfg_aggr_en(cfg_aggr_en), .cfg_hard_mode(cfg_hard_mode),
        .cfg_eof_close(cfg_eof_close), .cfg_limit_kb(cfg_limit_kb),
        .cfg_time_limit(cfg_time_limit), .cfg_tick_sel(cfg_tick_sel),
        .cfg_pkt_limit(cfg_pkt_limit),
        .tick_100us(tick_100us), .tick_1ms(tick_1ms),
        .pkt_valid(pkt_valid), .pkt_len(pkt_len), .pkt_eof(pkt_eof),
        .pkt_accept(pkt_accept), .pkt_defer(pkt_defer),
        .close_pulse(close_pulse), .close_reason(close_reason)
    );

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    // driver: one cycle with optional packet and ticks; pushes expected close
    task automatic step(input bit v, input int len, input bit eof, input bit t100, input bit t1m,
                        input bit exp_acc, input bit exp_close, input int rsn, input string rq);
        @(negedge clk);
        pkt_valid = v; pkt_len = 16'(len); pkt_eof = eof;
        tick_100us = t100; tick_1ms = t1m;
        #1;
        if (v) begin
            check(pkt_accept == exp_acc, {rq, " accept"}, int'(pkt_accept), int'(exp_acc));
            check(pkt_defer == !exp_acc, {rq, " defer"}, int'(pkt_defer), int'(!exp_acc));
        end
        if (exp_close) begin
            exp_rsn_q.push_back(rsn);
            exp_req_q.push_back(rq);
        end
        @(posedge clk);
        #2;
        pkt_valid = 1'b0; pkt_eof = 1'b0; tick_100us = 1'b0; tick_1ms = 1'b0;
    endtask

    task automatic pkt(input int len, input bit eof, input bit acc, input bit cl, input int rsn, input string rq);
        step(1'b1, len, eof, 1'b0, 1'b0, acc, cl, rsn, rq);
    endtask

    task automatic tick(input bit t100, input bit t1m, input bit cl, input string rq);
        step(1'b0, 0, 1'b0, t100, t1m, 1'b0, cl, 1, rq);
    endtask

    // monitor: compare every close against the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst && close_pulse) begin
                if (exp_rsn_q.size() == 0) begin
                    check(1'b0, "unexpected close", int'(close_reason), -1);
                end else begin
                    automatic int    e = exp_rsn_q.pop_front();
                    automatic string r = exp_req_q.pop_front();
                    check(int'(close_reason) == e, {r, " reason"}, int'(close_reason), e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(close_pulse == 1'b0, "R1 reset pulse", int'(close_pulse), 0);
        check(close_reason == 2'd0, "R1 reset reason", int'(close_reason), 0);

        // R2 soft boundary (1024 bytes)
        pkt(600, 0, 1, 0, 0, "R1 first pkt");
        pkt(600, 0, 1, 1, 0, "R2 soft cross");
        pkt(100, 0, 1, 0, 0, "R12 counters cleared");
        pkt(924, 0, 1, 1, 0, "R2 soft exact");

        // R3 hard boundary and re-presentation
        cfg_hard_mode = 1'b1;
        pkt(600, 0, 1, 0, 0, "R3 hard first");
        pkt(600, 0, 0, 1, 0, "R3 hard defer");
        pkt(600, 0, 1, 0, 0, "R3 hard replay");
        pkt(424, 0, 1, 1, 0, "R3 hard exact");
        // R4 oversize into empty buffer
        pkt(2000, 0, 1, 1, 0, "R4 oversize");
        cfg_hard_mode = 1'b0;

        // R8 end of frame
        cfg_eof_close = 1'b1;
        pkt(100, 1, 1, 1, 2, "R8 eof close");
        cfg_eof_close = 1'b0;
        pkt(100, 1, 1, 0, 0, "R8 eof ignored");
        pkt(1000, 0, 1, 1, 0, "R8 eof bytes kept");

        // R11 byte beats eof
        cfg_eof_close = 1'b1;
        pkt(1100, 1, 1, 1, 0, "R11 bytes over eof");
        cfg_eof_close = 1'b0;

        // R9 packet count
        cfg_pkt_limit = 6'd3;
        pkt(10, 0, 1, 0, 0, "R9 cnt 1");
        pkt(10, 0, 1, 0, 0, "R9 cnt 2");
        pkt(10, 0, 1, 1, 3, "R9 cnt 3");
        cfg_pkt_limit = 6'd0;
        for (int i = 0; i < 5; i++) pkt(10, 0, 1, 0, 0, "R9 unlimited");
        pkt(1024, 0, 1, 1, 0, "R9 flush");

        // R5 timer on 100us ticks, ticks while empty ignored
        cfg_time_limit = 8'd3;
        for (int i = 0; i < 5; i++) tick(1, 0, 0, "R5 empty tick");
        pkt(10, 0, 1, 0, 0, "R5 first write");
        tick(1, 0, 0, "R5 tick 1");
        tick(0, 1, 0, "R7 unselected tick");
        tick(1, 0, 0, "R5 tick 2");
        tick(1, 0, 1, "R5 tick 3 timeout");
        tick(1, 0, 0, "R12 timer idle");

        // R7 1ms tick select
        cfg_tick_sel = 1'b1; cfg_time_limit = 8'd2;
        pkt(10, 0, 1, 0, 0, "R7 write");
        for (int i = 0; i < 4; i++) tick(1, 0, 0, "R7 100us ignored");
        tick(0, 1, 0, "R7 ms 1");
        tick(0, 1, 1, "R7 ms 2 timeout");
        cfg_tick_sel = 1'b0;

        // R11 packet reason beats timer in the same cycle
        cfg_eof_close = 1'b1;
        pkt(10, 0, 1, 0, 0, "R11 write");
        tick(1, 0, 0, "R11 tick 1");
        step(1, 10, 1, 1, 0, 1, 1, 2, "R11 eof over timer");
        cfg_eof_close = 1'b0;

        // R6 timer disabled
        cfg_time_limit = 8'd0;
        pkt(10, 0, 1, 0, 0, "R6 write");
        for (int i = 0; i < 10; i++) tick(1, 0, 0, "R6 no timeout");
        pkt(1100, 0, 1, 1, 0, "R6 flush");

        // R10 aggregation disabled
        cfg_aggr_en = 1'b0; cfg_hard_mode = 1'b1; cfg_time_limit = 8'd1;
        pkt(10, 0, 1, 1, 3, "R10 small");
        pkt(5000, 0, 1, 1, 3, "R10 large");
        tick(1, 0, 0, "R10 tick ignored");

        repeat (3) @(posedge clk);
        #3;
        check(exp_rsn_q.size() == 0, "missing closes", exp_rsn_q.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule